// File: doc/BRIEF.md
# Parallel Port Reverse Nibble/Byte Receiver

This block sits on the host side of a parallel port and receives data from the peripheral in the reverse direction. It supports two transfer modes. In nibble mode the peripheral presents four bits at a time on the status lines. In byte mode it presents eight bits at a time on the data lines. Every transfer uses a two-phase handshake. The host pulls its ready line (`autofd_n`, active low) low. The peripheral presents data and pulls `ack_n` low. The host raises `autofd_n` to signal busy. The peripheral then releases `ack_n`.

In nibble mode two consecutive transfers form one byte, with the low nibble first. In byte mode the host drives a `strobe_n` pulse of programmable length after each handshake completes. Each completed byte appears on `rx_byte`, marked by a one-cycle `rx_valid` pulse. The acknowledge, status and data inputs come from another clock domain. All of them pass through multi-flop synchronizers before the handshake logic uses them. Clearing `enable` parks the block in an idle state.

Top module: `prt_rev_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `autofd_n` is 1, `strobe_n` is 1 and `rx_valid` is 0.
- R2: When `enable` is 0, the next cycle shows `autofd_n` = 1 and `strobe_n` = 1. Activity on `ack_n` during that time produces no `rx_valid`. A half-collected nibble pair is discarded, so the first nibble after re-enabling is again treated as the low nibble.
- R3: When enabled and waiting, `autofd_n` is 0. Once `ack_n` goes low, `autofd_n` returns to 1 exactly SYNC_STAGES+1 clock cycles later.
- R4: After raising `autofd_n`, the block keeps it high for as long as `ack_n` stays low. It drives `autofd_n` low again only after `ack_n` has been released.
- R5: In nibble mode (`byte_mode` = 0), the first transfer supplies `rx_byte[3:0]` and the second supplies `rx_byte[7:4]`. `rx_valid` pulses only after the second transfer.
- R6: In byte mode (`byte_mode` = 1), every transfer produces one `rx_valid` pulse, with `rx_byte` equal to `data_in`.
- R7: In byte mode, `strobe_n` goes low for exactly STROBE_CYCLES cycles after each release of `ack_n`, and the next ready phase starts only after that pulse. In nibble mode `strobe_n` never goes low.
- R8: `rx_valid` lasts exactly one cycle. `rx_byte` holds its value until the next byte completes.
- R9: The data and status inputs pass through the same synchronizer depth as `ack_n`. The value captured is the one present when `ack_n` fell. Changes on those inputs after `autofd_n` rises have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver enable; 0 forces idle |
| byte_mode | input | 1 | 0 = nibble transfers on status lines, 1 = byte transfers on data lines; change only while disabled |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| status_in | input | DATA_W/2 | Nibble from the peripheral status lines |
| data_in | input | DATA_W | Byte from the peripheral data lines |
| autofd_n | output | 1 | Host ready (0) / busy (1) handshake |
| strobe_n | output | 1 | Active-low strobe pulse after each byte-mode transfer |
| rx_byte | output | DATA_W | Last completed byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |

## Verification
Nibble mode is exercised with the bytes 0xA5, 0x3C, 0x0F and 0xF0. Because the two halves differ in each of these, a swapped nibble order or a missed half shows up at once. Byte mode is exercised with 0x00, 0xFF, 0x96 and 0x41, covering all-zero, all-one and mixed bit patterns, and the strobe width is measured after every byte. Several other cases are covered as well:
- A single nibble is followed by a disable and then by acknowledge pulses while disabled. This separates a design that correctly discards the pending half from one that keeps it or reacts while idle.
- In every transfer the bench scrambles the data lines after the busy edge. A long acknowledge hold checks that the block does not re-arm before `ack_n` is released.
- The bench measures the acknowledge-to-busy latency.

// File: rtl/prt_rev_pkg.sv
package prt_rev_pkg;

    localparam int DEF_DATA_W        = 8;
    localparam int DEF_SYNC_STAGES   = 2;
    localparam int DEF_STROBE_CYCLES = 4;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_READY  = 2'd1,
        RX_BUSY   = 2'd2,
        RX_STROBE = 2'd3
    } rx_state_e;

    typedef enum logic {
        XFER_NIBBLE = 1'b0,
        XFER_BYTE   = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/prt_rev_sync.sv
module prt_rev_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/prt_rev_pulse.sv
module prt_rev_pulse #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic active_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt_q <= '0;
        else if (start)          cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign active_n = (cnt_q == '0);
    assign done     = (cnt_q == CW'(1));

    // Counter never exceeds its programmed length (strobe width bound)
    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(CYCLES));

    // A pulse is never restarted while one is running
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        !active_n |-> !start);
endmodule

// File: rtl/prt_rev_fsm.sv
module prt_rev_fsm
    import prt_rev_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              byte_mode,
    input  logic              ack_s,
    input  logic [DATA_W/2-1:0] stat_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              pulse_done,
    output logic              autofd_n,
    output logic              pulse_start,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int NIB_W = DATA_W / 2;

    rx_state_e         state_q, state_d;
    logic              capture;
    logic              half_q;
    logic [NIB_W-1:0]  low_q;
    logic [DATA_W-1:0] byte_q;
    logic              valid_q;
    xfer_mode_e        mode;

    assign mode = xfer_mode_e'(byte_mode);

    always_comb begin
        state_d     = state_q;
        capture     = 1'b0;
        pulse_start = 1'b0;
        if (!enable) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  state_d = RX_READY;
                RX_READY: if (!ack_s) begin
                    capture = 1'b1;
                    state_d = RX_BUSY;
                end
                RX_BUSY: if (ack_s) begin
                    if (mode == XFER_BYTE) begin
                        pulse_start = 1'b1;
                        state_d     = RX_STROBE;
                    end else begin
                        state_d = RX_READY;
                    end
                end
                RX_STROBE: if (pulse_done) state_d = RX_READY;
                default:   state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            half_q  <= 1'b0;
            low_q   <= '0;
            byte_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= 1'b0;
            if (!enable) begin
                half_q <= 1'b0;
            end else if (capture) begin
                if (mode == XFER_BYTE) begin
                    byte_q  <= data_s;
                    valid_q <= 1'b1;
                end else if (!half_q) begin
                    low_q  <= stat_s;
                    half_q <= 1'b1;
                end else begin
                    byte_q  <= {stat_s, low_q};
                    valid_q <= 1'b1;
                    half_q  <= 1'b0;
                end
            end
        end
    end

    assign autofd_n = (state_q != RX_READY);
    assign rx_byte  = byte_q;
    assign rx_valid = valid_q;

    // Valid is a single-cycle pulse
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // Byte output only changes together with a valid pulse
    assert_byte_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_byte));

    // Busy is signalled only after the synchronized acknowledge was seen, or on disable
    assert_busy_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(autofd_n) |-> (!$past(ack_s) || !$past(enable)));

    // A new byte appears together with the busy level on the handshake line
    assert_valid_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> autofd_n);
endmodule

// File: rtl/prt_rev_rx.sv
module prt_rev_rx
    import prt_rev_pkg::*;
#(
    parameter int DATA_W        = DEF_DATA_W,
    parameter int SYNC_STAGES   = DEF_SYNC_STAGES,
    parameter int STROBE_CYCLES = DEF_STROBE_CYCLES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                byte_mode,
    input  logic                ack_n,
    input  logic [DATA_W/2-1:0] status_in,
    input  logic [DATA_W-1:0]   data_in,
    output logic                autofd_n,
    output logic                strobe_n,
    output logic [DATA_W-1:0]   rx_byte,
    output logic                rx_valid
);
    localparam int NIB_W = DATA_W / 2;

    logic              ack_s;
    logic [NIB_W-1:0]  stat_s;
    logic [DATA_W-1:0] data_s;
    logic              pulse_start;
    logic              pulse_done;

    prt_rev_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ack (
        .clk(clk), .rst(rst), .d(ack_n), .q(ack_s)
    );

    prt_rev_sync #(.W(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_stat (
        .clk(clk), .rst(rst), .d(status_in), .q(stat_s)
    );

    prt_rev_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst(rst), .d(data_in), .q(data_s)
    );

    prt_rev_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .enable(enable), .byte_mode(byte_mode),
        .ack_s(ack_s), .stat_s(stat_s), .data_s(data_s),
        .pulse_done(pulse_done), .autofd_n(autofd_n),
        .pulse_start(pulse_start), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    prt_rev_pulse #(.CYCLES(STROBE_CYCLES)) u_strobe (
        .clk(clk), .rst(rst), .clr(!enable), .start(pulse_start),
        .active_n(strobe_n), .done(pulse_done)
    );

    // Disable forces the idle levels on both handshake outputs
    assert_disable_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (autofd_n && strobe_n));

    // Strobe only while the ready line is released
    assert_strobe_busy_R7: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> autofd_n);

    // No strobe in nibble mode
    assert_no_nibble_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !byte_mode |-> strobe_n);
endmodule

// File: tb/tb_prt_rev_rx.sv
module tb_prt_rev_rx;
    localparam int DATA_W = 8;
    localparam int SYNC   = 2;
    localparam int STRB   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic byte_mode = 1'b0;
    logic ack_n = 1'b1;
    logic [3:0] status_in = '0;
    logic [7:0] data_in = '0;
    logic autofd_n, strobe_n, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;
    int stray_strobe = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    prt_rev_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC), .STROBE_CYCLES(STRB)) dut (
        .clk(clk), .rst(rst), .enable(enable), .byte_mode(byte_mode),
        .ack_n(ack_n), .status_in(status_in), .data_in(data_in),
        .autofd_n(autofd_n), .strobe_n(strobe_n),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard: pops an expected byte for every valid pulse
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R5 unexpected byte", rx_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_byte == e, "R5/R6 byte", rx_byte, e);
                end
                check(!prev_valid, "R8 valid width", 1, 0);
            end
            if (!byte_mode && !strobe_n) stray_strobe++;
            prev_valid <= rx_valid;
        end
    end

    task automatic wait_ready();
        int n = 0;
        while (autofd_n !== 1'b0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(autofd_n == 1'b0, "R3 ready asserted", autofd_n, 0);
    endtask

    // Peripheral model: one handshake carrying a nibble or a byte
    task automatic xfer(input logic [7:0] v, input bit is_byte, input bit long_hold);
        int n;
        wait_ready();
        if (is_byte) data_in = v; else status_in = v[3:0];
        ack_n = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (autofd_n == 1'b0 && n < 50);
        check(n == SYNC + 1, "R3 ack-to-busy latency", n, SYNC + 1);
        // Scramble the lines after busy: must not affect the captured value (R9)
        data_in   = ~v;
        status_in = ~v[3:0];
        if (long_hold) begin
            bit held = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (autofd_n != 1'b1) held = 1'b0;
            end
            check(held, "R4 busy held while ack low", held, 1);
        end
        ack_n = 1'b1;
        if (is_byte) begin
            int low = 0;
            n = 0;
            while (strobe_n == 1'b1 && n < 20) begin
                @(negedge clk);
                n++;
            end
            while (strobe_n == 1'b0 && low < 50) begin
                check(autofd_n == 1'b1, "R7 no ready during strobe", autofd_n, 1);
                @(negedge clk);
                low++;
            end
            check(low == STRB, "R7 strobe width", low, STRB);
        end
    endtask

    task automatic send_nibble_byte(input logic [7:0] v);
        exp_q.push_back(v);
        xfer({4'h0, v[3:0]}, 1'b0, 1'b0);
        xfer({4'h0, v[7:4]}, 1'b0, 1'b0);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit long_hold);
        exp_q.push_back(v);
        xfer(v, 1'b1, long_hold);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(autofd_n == 1 && strobe_n == 1 && rx_valid == 0, "R1 reset levels",
              {autofd_n, strobe_n, rx_valid}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        check(autofd_n == 1 && strobe_n == 1 && rx_valid == 0, "R1 after reset",
              {autofd_n, strobe_n, rx_valid}, 3'b110);

        // Nibble mode
        byte_mode = 1'b0;
        enable = 1'b1;
        send_nibble_byte(8'hA5);
        send_nibble_byte(8'h3C);
        send_nibble_byte(8'h0F);
        exp_q.push_back(8'hF0);
        xfer(8'h00, 1'b0, 1'b1);   // R4: long hold on the low half
        xfer(8'h0F, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        check(rx_byte == 8'hF0, "R8 byte held", rx_byte, 8'hF0);

        // Disable with a half-collected pair pending (R2)
        xfer(8'h07, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(autofd_n == 1 && strobe_n == 1, "R2 idle on disable",
              {autofd_n, strobe_n}, 2'b11);
        repeat (3) begin
            status_in = 4'hE;
            ack_n = 1'b0;
            repeat (5) @(negedge clk);
            check(autofd_n == 1, "R2 ack ignored while disabled", autofd_n, 1);
            ack_n = 1'b1;
            repeat (5) @(negedge clk);
        end
        check(exp_q.size() == 0, "R2 no byte while disabled", exp_q.size(), 0);
        enable = 1'b1;
        send_nibble_byte(8'h5B);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R5 nibble bytes all produced", exp_q.size(), 0);

        // Byte mode
        enable = 1'b0;
        repeat (3) @(negedge clk);
        byte_mode = 1'b1;
        enable = 1'b1;
        send_byte(8'h00, 1'b0);
        send_byte(8'hFF, 1'b1);
        send_byte(8'h96, 1'b0);
        send_byte(8'h41, 1'b0);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R6 bytes all produced", exp_q.size(), 0);
        check(rx_byte == 8'h41, "R8 last byte held", rx_byte, 8'h41);
        check(stray_strobe == 0, "R7 no strobe in nibble mode", stray_strobe, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule